// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws axis-aligned rectangles into a 16-bit-per-pixel frame buffer that sits in an external synchronous memory. Software feeds it 32-bit command words. The top byte of each word is an opcode and the low bits carry an operand. Parameter words set the destination origin, the source origin, the rectangle extent and a fill colour. These values stay in their registers until they are overwritten. A start word then launches one of two operations: a solid fill of the rectangle, or a copy of an equally sized rectangle from the source origin to the destination origin.

The engine walks the rectangle one pixel at a time. It goes left to right along each row and then moves down to the next row. The row pitch comes from a line-width input, given in pixels. A fill writes one pixel per cycle. A copy spends two cycles per pixel: one cycle to read the source pixel and one to write it. Command words are taken only while the engine is idle. When the last pixel is written, `busy` falls and `done` pulses in the same cycle.

Top module: `rbe_blit_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_wr_en` are low and `cmd_ready` is high.
- R2: A word with opcode 0x0C in bits 31:24 sets the destination byte address to bits 23:0 of the word, with bit 0 forced to zero.
- R3: A word with opcode 0x0D sets the source byte address in the same way, with bit 0 forced to zero.
- R4: Opcode 0x0E sets the row length minus one, and opcode 0x0F sets the row count minus one. Each value is taken from bits 9:0 of the word. A value of n therefore covers n+1 pixels, up to 1024.
- R5: Opcode 0x0B sets the fill colour from bits 15:0 of the word. A start word with opcode 0x23 writes that colour to every pixel of the rectangle and to no other pixel.
- R6: A start word with opcode 0x21 copies each source pixel to the destination pixel at the same offset within the rectangle. Each pixel is read and then written before the engine moves to the next one.
- R7: Pixel (x, y) sits at byte address base + (y*line_px + x)*2. Writes happen in raster order: x increases first, then y.
- R8: `busy` is high from the cycle after a start word is accepted. It stays high for exactly N cycles for a fill and exactly 2N cycles for a copy, where N is the pixel count. It then falls in the same cycle that `done` is high for one cycle.
- R9: Parameter values remain in place after an operation, so a start word on its own repeats the operation with the same geometry.
- R10: A word with any other opcode changes no parameter and starts nothing.
- R11: While `busy` is high, `cmd_ready` is low and a presented command word is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_px | input | 11 | Line width in pixels (row pitch) |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Command word: opcode in 31:24, operand below |
| cmd_ready | output | 1 | Engine idle; the word is taken on this edge |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Source pixel read request |
| mem_rd_addr | output | 24 | Source byte address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Pixel write strobe |
| mem_wr_addr | output | 24 | Destination byte address |
| mem_wr_data | output | 16 | Pixel value written |

## Verification
A corrupted position counter or row base shows up at once. The next write strobe carries an address that is off the raster sequence, and the bench compares every strobe against the computed sequence. A wrong extent or a wrong copy phase does not show in the address stream. It changes the busy length or the write count, which is visible when `done` arrives. A parameter register that takes a stray or ignored word is found on the next operation, because pixels then land in the wrong place or carry the wrong colour. The full-memory comparison after each operation catches this.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_CRD  = 2'd2,
      ST_CWR  = 2'd3
   } eng_st_t;

   localparam logic [7:0] OP_FILLCOL = 8'h0B;
   localparam logic [7:0] OP_DSTORG  = 8'h0C;
   localparam logic [7:0] OP_SRCORG  = 8'h0D;
   localparam logic [7:0] OP_WIDM1   = 8'h0E;
   localparam logic [7:0] OP_HGTM1   = 8'h0F;
   localparam logic [7:0] OP_GOCOPY  = 8'h21;
   localparam logic [7:0] OP_GOFILL  = 8'h23;
endpackage

// File: rtl/rbe_param_regs.sv
module rbe_param_regs
   import rbe_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 10,
   parameter int PIX_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [31:0]       word,
   output logic [ADDR_W-1:0] dst_org,
   output logic [ADDR_W-1:0] src_org,
   output logic [CNT_W-1:0]  wid_m1,
   output logic [CNT_W-1:0]  hgt_m1,
   output logic [PIX_W-1:0]  colour,
   output logic              go_fill,
   output logic              go_copy
);
   localparam int OPND_W = 24;

   generate
      if (ADDR_W > OPND_W || ADDR_W < CNT_W + 3) begin : g_bad_addr
         $error("rbe_param_regs: ADDR_W out of range");
      end
      if (PIX_W > OPND_W || CNT_W > 16) begin : g_bad_field
         $error("rbe_param_regs: field width out of range");
      end
   endgenerate

   logic [7:0] opc;
   logic       known;
   assign opc     = word[31:24];
   assign go_fill = accept && (opc == OP_GOFILL);
   assign go_copy = accept && (opc == OP_GOCOPY);
   assign known   = (opc == OP_FILLCOL) || (opc == OP_DSTORG) || (opc == OP_SRCORG) ||
                    (opc == OP_WIDM1) || (opc == OP_HGTM1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_org <= '0;
         src_org <= '0;
         wid_m1  <= '0;
         hgt_m1  <= '0;
         colour  <= '0;
      end else if (accept) begin
         case (opc)
            OP_DSTORG:  dst_org <= {word[ADDR_W-1:1], 1'b0};
            OP_SRCORG:  src_org <= {word[ADDR_W-1:1], 1'b0};
            OP_WIDM1:   wid_m1  <= word[CNT_W-1:0];
            OP_HGTM1:   hgt_m1  <= word[CNT_W-1:0];
            OP_FILLCOL: colour  <= word[PIX_W-1:0];
            default: ;
         endcase
      end
   end

   // R10: a word that loads no parameter leaves every parameter as it was
   a_r10_unknown_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !known) |=> ($stable(dst_org) && $stable(src_org) && $stable(wid_m1) &&
                              $stable(hgt_m1) && $stable(colour)));
   // R2 / R3: origins are always even
   a_r2_even_origin: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_org[0] && !src_org[0]);
endmodule

// File: rtl/rbe_walker.sv
module rbe_walker #(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [CNT_W-1:0]  wid_m1,
   input  logic [CNT_W-1:0]  hgt_m1,
   input  logic [CNT_W:0]    line_px,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [ADDR_W-1:0] src_addr,
   output logic              last
);
   logic [CNT_W-1:0]  xpos, ypos;
   logic [ADDR_W-1:0] drow, srow, pitch_b, xoff_b;
   logic              row_end;

   assign pitch_b  = ADDR_W'({line_px, 1'b0});
   assign xoff_b   = ADDR_W'({xpos, 1'b0});
   assign dst_addr = drow + xoff_b;
   assign src_addr = srow + xoff_b;
   assign row_end  = (xpos == wid_m1);
   assign last     = row_end && (ypos == hgt_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xpos <= '0;
         ypos <= '0;
         drow <= '0;
         srow <= '0;
      end else if (start) begin
         xpos <= '0;
         ypos <= '0;
         drow <= dst_base;
         srow <= src_base;
      end else if (step) begin
         if (row_end) begin
            xpos <= '0;
            ypos <= ypos + 1'b1;
            drow <= drow + pitch_b;
            srow <= srow + pitch_b;
         end else begin
            xpos <= xpos + 1'b1;
         end
      end
   end

   // R7: within a row the next pixel sits two bytes further on
   a_r7_step_right: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && !row_end) |=> (dst_addr == $past(dst_addr) + ADDR_W'(2)));
   // R7: a row wrap moves back to the row start plus one pitch
   a_r7_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && row_end && !last) |=> (dst_addr == $past(drow) + pitch_b));
endmodule

// File: rtl/rbe_blit_engine.sv
module rbe_blit_engine
   import rbe_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 10,
   parameter int PIX_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W:0]    line_px,
   input  logic              cmd_valid,
   input  logic [31:0]       cmd_word,
   output logic              cmd_ready,
   output logic              busy,
   output logic              done,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [PIX_W-1:0]  mem_rd_data,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [PIX_W-1:0]  mem_wr_data
);
   eng_st_t           st;
   logic              accept, go_fill, go_copy, step, last;
   logic [ADDR_W-1:0] dst_org, src_org, dst_addr, src_addr;
   logic [CNT_W-1:0]  wid_m1, hgt_m1;
   logic [PIX_W-1:0]  colour;
   logic              done_q;

   assign cmd_ready = (st == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign busy      = (st != ST_IDLE);
   assign done      = done_q;
   assign step      = (st == ST_FILL) || (st == ST_CWR);

   rbe_param_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PIX_W(PIX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .accept(accept), .word(cmd_word),
      .dst_org(dst_org), .src_org(src_org), .wid_m1(wid_m1), .hgt_m1(hgt_m1),
      .colour(colour), .go_fill(go_fill), .go_copy(go_copy)
   );

   rbe_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(go_fill || go_copy), .step(step),
      .dst_base(dst_org), .src_base(src_org), .wid_m1(wid_m1), .hgt_m1(hgt_m1),
      .line_px(line_px), .dst_addr(dst_addr), .src_addr(src_addr), .last(last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         done_q <= step && last;
         case (st)
            ST_IDLE: begin
               if (go_fill)      st <= ST_FILL;
               else if (go_copy) st <= ST_CRD;
            end
            ST_FILL: if (last) st <= ST_IDLE;
            ST_CRD:  st <= ST_CWR;
            ST_CWR:  st <= last ? ST_IDLE : ST_CRD;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_en   = (st == ST_CRD);
   assign mem_rd_addr = src_addr;
   assign mem_wr_en   = step;
   assign mem_wr_addr = dst_addr;
   assign mem_wr_data = (st == ST_FILL) ? colour : mem_rd_data;

   // R8: completion pulse coincides with busy low and lasts one cycle
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: every copy write is preceded by its source read
   a_r6_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CWR) |-> $past(mem_rd_en));
   // R11: no command is taken during an operation
   a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(dst_org) && $stable(colour) && $stable(wid_m1));
   // R7: write addresses stay even
   a_r7_even_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !mem_wr_addr[0]);
endmodule

// File: tb/sim_rbe_blit_engine.sv
`timescale 1ns/1ps
module sim_rbe_blit_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] line_px = 11'd20;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_word = '0;
   logic        cmd_ready, busy, done, mem_rd_en, mem_wr_en;
   logic [23:0] mem_rd_addr, mem_wr_addr;
   logic [15:0] mem_rd_data, mem_wr_data;

   always #2.5 clk = ~clk;

   rbe_blit_engine u0 (
      .clk(clk), .rst_n(rst_n), .line_px(line_px), .cmd_valid(cmd_valid),
      .cmd_word(cmd_word), .cmd_ready(cmd_ready), .busy(busy), .done(done),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   logic [15:0] mem [0:4095];
   logic [15:0] emem[0:4095];
   int n_chk = 0, n_bad = 0;
   int wr_cnt = 0, ord_bad = 0;
   int m_dst = 0, m_w = 0, m_stride = 20;
   int cur_dst = 0, cur_src = 0, cur_w = 0, cur_h = 0, cur_col = 0;

   function automatic int exp_addr(int base, int stride, int w, int i);
      return base + ((i / (w + 1)) * stride + (i % (w + 1))) * 2;
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[12:1]];
      if (mem_wr_en) begin
         mem[mem_wr_addr[12:1]] <= mem_wr_data;
         if (!busy || int'(mem_wr_addr) != exp_addr(m_dst, m_stride, m_w, wr_cnt)) ord_bad++;
         wr_cnt++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = w;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic model(input bit is_copy);
      for (int y = 0; y <= cur_h; y++)
         for (int x = 0; x <= cur_w; x++) begin
            int d = (cur_dst / 2) + y * int'(line_px) + x;
            int s = (cur_src / 2) + y * int'(line_px) + x;
            emem[d] = is_copy ? emem[s] : 16'(cur_col);
         end
   endtask

   task automatic go_and_check(input bit is_copy, input string tag);
      int cyc = 0;
      int npx = (cur_w + 1) * (cur_h + 1);
      int diffs = 0;
      model(is_copy);
      m_dst = cur_dst; m_w = cur_w; m_stride = int'(line_px);
      wr_cnt = 0; ord_bad = 0;
      send(is_copy ? 32'h2100_0000 : 32'h2300_0000);
      chk(busy == 1'b1, {tag, " R8 busy after go"}, busy, 1);
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc == (is_copy ? 2 * npx : npx), {tag, " R8 busy length"}, cyc, is_copy ? 2 * npx : npx);
      chk(busy == 1'b0 && cmd_ready == 1'b1, {tag, " R8 busy low at done"}, busy, 0);
      chk(wr_cnt == npx, {tag, " R4 write count"}, wr_cnt, npx);
      chk(ord_bad == 0, {tag, " R7 raster order"}, ord_bad, 0);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
      for (int i = 0; i < 4096; i++) if (mem[i] !== emem[i]) diffs++;
      chk(diffs == 0, {tag, is_copy ? " R6 copy contents" : " R5 fill contents"}, diffs, 0);
   endtask

   task automatic set_all(input int d, input int s, input int w, input int h, input int c);
      cur_dst = d & 24'hFFFFFE; cur_src = s & 24'hFFFFFE;
      cur_w = w; cur_h = h; cur_col = c;
      send(32'h0C00_0000 | (d & 24'hFFFFFF));
      send(32'h0D00_0000 | (s & 24'hFFFFFF));
      send(32'h0E00_0000 | w);
      send(32'h0F00_0000 | h);
      send(32'h0B00_0000 | c);
   endtask

   initial begin
      #900000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4219));
      for (int i = 0; i < 4096; i++) begin
         mem[i]  = 16'($urandom);
         emem[i] = mem[i];
      end
      repeat (4) @(negedge clk);
      chk(!busy && !done && !mem_wr_en && cmd_ready, "R1 reset state",
          {busy, done, mem_wr_en, cmd_ready}, 4'b0001);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: odd destination operand is forced even
      line_px = 11'd20;
      set_all(32'h0401, 32'h1201, 3, 2, 32'hABCD);
      go_and_check(1'b0, "fill odd dst R2");

      // R9: only colour changes, geometry persists
      send(32'h0B00_1234); cur_col = 32'h1234;
      go_and_check(1'b0, "repeat fill R9");

      // R10: unknown opcodes change nothing
      send(32'h0500_0000); send(32'h30FF_FFFF); send(32'h2200_0002); send(32'h0A00_0000);
      go_and_check(1'b0, "after unknown R10");

      // R3/R6: copy single pixel with odd source operand
      set_all(32'h0100, 32'h1303, 0, 0, 32'h0);
      go_and_check(1'b1, "copy 1px R3");

      // R6: copy multi-row rectangle
      set_all(32'h0300, 32'h1400, 5, 3, 32'h0);
      go_and_check(1'b1, "copy 6x4 R6");

      // R11: words presented while busy are not taken
      set_all(32'h0600, 32'h1400, 7, 5, 32'h5A5A);
      model(1'b0);
      m_dst = cur_dst; m_w = cur_w; m_stride = int'(line_px);
      wr_cnt = 0; ord_bad = 0;
      send(32'h2300_0000);
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R11 ready low while busy", cmd_ready, 0);
      cmd_valid = 1'b1; cmd_word = 32'h0C00_0000;
      @(negedge clk); cmd_word = 32'h0B00_FFFF;
      @(negedge clk); cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      send(32'h0E00_0007); // same width, keeps model aligned
      go_and_check(1'b0, "refill after busy words R11");

      // R4: widest row, 1024 pixels
      line_px = 11'd1024;
      set_all(32'h0000, 32'h1000, 1023, 0, 32'h0F0F);
      go_and_check(1'b0, "full width R4");

      // random mix
      for (int k = 0; k < 20; k++) begin
         bit cp = $urandom_range(0, 1);
         line_px = 11'($urandom_range(16, 40));
         set_all($urandom_range(0, 1700) * 2, (2048 + $urandom_range(0, 1700)) * 2,
                 $urandom_range(0, 7), $urandom_range(0, 5), $urandom_range(0, 65535));
         go_and_check(cp, cp ? "random copy R6" : "random fill R5");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule